// File: doc/BRIEF.md
# SPI Master Slave-Select Timing Sequencer

This block frames single-byte transfers for an SPI master. A start strobe pulls slave-select low. The block then holds the serial clock idle for a lead interval, clocks eight data bits out and in (mode 0, most significant bit first) and holds the clock idle again for a lag interval. It then releases slave-select and raises a one-cycle done pulse.

Each interval lasts either one serial-clock period or a programmed count of one to eight periods. A bank of command slots makes that choice. Each slot carries a lead-enable bit and a lag-enable bit. The two 3-bit delay fields are shared by all slots. A slot pointer picks the slot for each transfer and steps to the next slot after each one.

One serial-clock period is `DIV` system clocks, with sck high for the first half and low for the second half. The states are IDLE, ASSERT (slave-select just driven low), LEAD (lead delay), SHIFT (eight clock pulses), LAG (lag delay) and NEGATE (slave-select high, done). The transitions are:
- IDLE→ASSERT on start.
- ASSERT→LEAD always.
- LEAD→SHIFT when the lead count expires.
- SHIFT→LAG on the eighth falling sck edge.
- LAG→NEGATE when the lag count expires.
- NEGATE→IDLE always.

Top module: `spi_cs_seq`

## Requirements
- R1: After reset ss_n=1, sck=0, mosi=0, busy=0, done=0 and slot=0.
- R2: A start seen in IDLE drives ss_n low and busy high on the next clock edge. While the block is not busy, ss_n is 1.
- R3: When the current slot's lead-enable bit is 0, exactly DIV system clocks pass from the ss_n falling edge to the first sck rising edge, whatever the value of lead_dly.
- R4: When the lead-enable bit is 1, that gap is (lead_dly+1)*DIV system clocks: lead_dly=0 gives 1 period and lead_dly=7 gives 8 periods.
- R5: When the current slot's lag-enable bit is 0, exactly DIV system clocks pass from the last sck falling edge to the ss_n rising edge, whatever the value of lag_dly.
- R6: When the lag-enable bit is 1, that gap is (lag_dly+1)*DIV system clocks.
- R7: Each transfer has exactly 8 sck pulses, each high for DIV/2 clocks. sck is 0 in every other state, and sck is never high while ss_n is 1.
- R8: mosi carries tx_data with bit 7 first and is stable at each sck rising edge. miso is sampled during each high phase. At done, rx_data holds the received bits with the first bit in bit 7.
- R9: done is high for exactly one clock, in the cycle where ss_n returns to 1.
- R10: slot gives the command slot for the next transfer. It indexes bit `slot` of lead_en and lag_en, steps by one after each transfer and wraps from NSLOT-1 to 0.
- R11: A start that arrives while busy is ignored. The running transfer keeps its timing, and no second frame follows it.
- R12: The delay fields, enable bits and tx_data are captured at start. Changing them during a transfer does not alter that transfer's timing or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transfer request, taken only in IDLE |
| tx_data | input | W | Byte to transmit |
| lead_en | input | NSLOT | Per-slot lead-delay enable |
| lag_en | input | NSLOT | Per-slot lag-delay enable |
| lead_dly | input | 3 | Shared lead-delay field (periods minus one) |
| lag_dly | input | 3 | Shared lag-delay field (periods minus one) |
| miso | input | 1 | Serial data from the slave |
| ss_n | output | 1 | Active-low slave-select |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the slave |
| rx_data | output | W | Received byte |
| done | output | 1 | One-cycle end-of-transfer pulse |
| busy | output | 1 | High from ASSERT through LAG |
| slot | output | SW | Command slot used by the next transfer |

## Verification
The bench builds the block with DIV=4 and NSLOT=3. With these values an 8-period delay is only 32 clocks, so many transfers fit in a short run. Three slots make the pointer wrap every third transfer, and the wrap falls on a slot whose enable bits differ from slot 0's. With a two-clock half period, every off-by-one in the lead, lag or pulse-width counts shows up as a wrong clock count at the ports.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASSERT,
        ST_LEAD,
        ST_SHIFT,
        ST_LAG,
        ST_NEGATE
    } seq_state_t;

    // Number of serial-clock periods for one interval: 1 when disabled, field+1 otherwise.
    function automatic logic [3:0] interval_periods(input logic en, input logic [2:0] field);
        return en ? ({1'b0, field} + 4'd1) : 4'd1;
    endfunction

endpackage

// File: rtl/spi_seq_tick.sv
module spi_seq_tick #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt <= '0;
        else if (!run)                  cnt <= '0;
        else if (cnt == CW'(HALF - 1))  cnt <= '0;
        else                            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == CW'(HALF - 1));

    // half-period ticks are never back to back (R7 pulse width)
    assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/spi_seq_slot.sv
module spi_seq_slot #(
    parameter int NSLOT = 4,
    localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [SW-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           ptr <= '0;
        else if (adv && ptr == SW'(NSLOT-1))  ptr <= '0;
        else if (adv)                         ptr <= ptr + 1'b1;
    end

    assert_slot_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr));

    assert_slot_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= SW'(NSLOT-1));

endmodule

// File: rtl/spi_seq_shreg.sv
module spi_seq_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    input  logic         sin,
    output logic [W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     dout <= '0;
        else if (load)  dout <= din;
        else if (shift) dout <= {dout[W-2:0], sin};
    end

endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
    import spi_seq_pkg::*;
#(
    parameter int DIV   = 8,
    parameter int NSLOT = 4,
    parameter int W     = 8,
    localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     tx_data,
    input  logic [NSLOT-1:0] lead_en,
    input  logic [NSLOT-1:0] lag_en,
    input  logic [2:0]       lead_dly,
    input  logic [2:0]       lag_dly,
    input  logic             miso,
    output logic             ss_n,
    output logic             sck,
    output logic             mosi,
    output logic [W-1:0]     rx_data,
    output logic             done,
    output logic             busy,
    output logic [SW-1:0]    slot
);
    localparam int HALF = DIV / 2;
    localparam int CW   = $clog2(8 * DIV + 1);
    localparam int BW   = $clog2(W);

    seq_state_t    state, nxt;
    logic [3:0]    lead_q, lag_q;
    logic [CW-1:0] cnt;
    logic          sck_q;
    logic [BW-1:0] bits;
    logic          tick, fall_tick, last_fall, accept;
    logic [W-1:0]  sh;

    assign accept    = (state == ST_IDLE) && start;
    assign fall_tick = (state == ST_SHIFT) && tick && sck_q;
    assign last_fall = fall_tick && (bits == BW'(W - 1));

    spi_seq_tick #(.HALF(HALF)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(state == ST_SHIFT), .tick(tick)
    );

    spi_seq_slot #(.NSLOT(NSLOT)) u_slot (
        .clk(clk), .rst_n(rst_n), .adv(state == ST_NEGATE), .ptr(slot)
    );

    spi_seq_shreg #(.W(W)) u_sh (
        .clk(clk), .rst_n(rst_n), .load(accept), .shift(fall_tick),
        .din(tx_data), .sin(miso), .dout(sh)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start)            nxt = ST_ASSERT;
            ST_ASSERT:                       nxt = ST_LEAD;
            ST_LEAD:   if (cnt == '0)        nxt = ST_SHIFT;
            ST_SHIFT:  if (last_fall)        nxt = ST_LAG;
            ST_LAG:    if (cnt == '0)        nxt = ST_NEGATE;
            ST_NEGATE:                       nxt = ST_IDLE;
            default:                         nxt = ST_IDLE;
        endcase
    end

    // captured settings, interval counter, clock phase and bit count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lead_q <= 4'd1;
            lag_q  <= 4'd1;
            cnt    <= '0;
            sck_q  <= 1'b0;
            bits   <= '0;
        end else begin
            if (accept) begin
                lead_q <= interval_periods(lead_en[slot], lead_dly);
                lag_q  <= interval_periods(lag_en[slot],  lag_dly);
            end

            if (state == ST_ASSERT)  cnt <= CW'(32'(lead_q) * DIV - 2);
            else if (last_fall)      cnt <= CW'(32'(lag_q) * DIV - 1);
            else if (cnt != '0)      cnt <= cnt - 1'b1;

            if (state == ST_LEAD && cnt == '0)   sck_q <= 1'b1;
            else if (state == ST_SHIFT && tick)  sck_q <= ~sck_q;
            else if (state != ST_SHIFT)          sck_q <= 1'b0;

            if (state == ST_LEAD)  bits <= '0;
            else if (fall_tick)    bits <= bits + 1'b1;
        end
    end

    // outputs
    always_comb begin
        ss_n = 1'b0;
        sck  = 1'b0;
        mosi = 1'b0;
        done = 1'b0;
        busy = 1'b1;
        unique case (state)
            ST_IDLE:   begin ss_n = 1'b1; busy = 1'b0; end
            ST_SHIFT:  begin sck = sck_q; mosi = sh[W-1]; end
            ST_NEGATE: begin ss_n = 1'b1; busy = 1'b0; done = 1'b1; end
            default:   ;
        endcase
    end

    assign rx_data = sh;

    assert_ss_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ss_n);

    assert_start_frames_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start) |=> (busy && !ss_n));

    assert_sck_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !ss_n);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_on_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(ss_n));

    assert_slot_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (slot != $past(slot)) || (NSLOT == 1));

    assert_settings_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(lead_q) && $stable(lag_q)));

    assert_mosi_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(mosi) || $past(state) == ST_LEAD);

endmodule

// File: tb/tb_spi_cs_seq.sv
module tb_spi_cs_seq;
    localparam int DIV   = 4;
    localparam int NSLOT = 3;
    localparam int W     = 8;
    localparam int HALF  = DIV / 2;
    localparam int SW    = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [W-1:0]     tx_data = '0;
    logic [NSLOT-1:0] lead_en = '0, lag_en = '0;
    logic [2:0]       lead_dly = '0, lag_dly = '0;
    logic             miso = 1'b0;
    logic             ss_n, sck, mosi, done, busy;
    logic [W-1:0]     rx_data;
    logic [SW-1:0]    slot;

    int cyc = 0;
    int checks = 0;
    int bad = 0;
    int exp_slot = 0;
    bit finished = 1'b0;

    spi_cs_seq #(.DIV(DIV), .NSLOT(NSLOT), .W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data),
        .lead_en(lead_en), .lag_en(lag_en), .lead_dly(lead_dly), .lag_dly(lag_dly),
        .miso(miso), .ss_n(ss_n), .sck(sck), .mosi(mosi), .rx_data(rx_data),
        .done(done), .busy(busy), .slot(slot)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int periods(input logic en, input logic [2:0] f);
        return en ? (int'(f) + 1) : 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one full transfer; mutate=1 changes all settings and re-strobes start mid-frame
    task automatic xfer(input logic [W-1:0] tx, input logic [W-1:0] pat,
                        input logic [NSLOT-1:0] le, input logic [NSLOT-1:0] ge,
                        input logic [2:0] ld, input logic [2:0] gd, input bit mutate);
        int t_fall, first_rise, rise_t, last_fall, t_rel, nrise, guard;
        int exp_lead, exp_lag;
        logic prev;
        bit lead_req_en, lag_req_en;
        @(negedge clk);
        check(int'(slot) == exp_slot, "R10 slot before start", int'(slot), exp_slot);
        lead_req_en = le[exp_slot];
        lag_req_en  = ge[exp_slot];
        exp_lead = periods(lead_req_en, ld) * DIV;
        exp_lag  = periods(lag_req_en, gd) * DIV;
        tx_data = tx; lead_en = le; lag_en = ge; lead_dly = ld; lag_dly = gd;
        miso = pat[W-1];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(ss_n == 1'b0 && busy == 1'b1, "R2 ss_n low after start", int'(ss_n), 0);
        t_fall = cyc; first_rise = -1; rise_t = 0; last_fall = 0; nrise = 0;
        prev = 1'b0; guard = 0;
        while (ss_n == 1'b0 && guard < 2000) begin
            if (mutate && guard == 0) begin
                tx_data = ~tx; lead_en = ~le; lag_en = ~ge;
                lead_dly = ~ld; lag_dly = ~gd; start = 1'b1;
            end else if (mutate && guard == 1) begin
                start = 1'b0;
            end
            @(negedge clk);
            guard++;
            if (sck && !prev) begin
                if (first_rise < 0) first_rise = cyc;
                rise_t = cyc;
                check(mosi == tx[W-1-nrise], mutate ? "R12 mosi bit" : "R8 mosi bit",
                      int'(mosi), int'(tx[W-1-nrise]));
                nrise++;
            end
            if (!sck && prev) begin
                last_fall = cyc;
                check(cyc - rise_t == HALF, "R7 high width", cyc - rise_t, HALF);
                if (nrise < W) miso = pat[W-1-nrise];
            end
            if (sck) check(!ss_n, "R7 sck only in frame", int'(ss_n), 0);
            prev = sck;
        end
        t_rel = cyc;
        check(nrise == W, "R7 pulse count", nrise, W);
        check(first_rise - t_fall == exp_lead,
              mutate ? "R12 lead kept" : (lead_req_en ? "R4 lead programmed" : "R3 lead fixed"),
              first_rise - t_fall, exp_lead);
        check(t_rel - last_fall == exp_lag,
              mutate ? "R12 lag kept" : (lag_req_en ? "R6 lag programmed" : "R5 lag fixed"),
              t_rel - last_fall, exp_lag);
        check(done == 1'b1, "R9 done with release", int'(done), 1);
        check(rx_data == pat, "R8 rx_data", int'(rx_data), int'(pat));
        exp_slot = (exp_slot + 1) % NSLOT;
        @(negedge clk);
        check(done == 1'b0, "R9 done one cycle", int'(done), 0);
        check(int'(slot) == exp_slot, "R10 slot stepped", int'(slot), exp_slot);
        if (mutate) begin
            repeat (4) @(negedge clk);
            check(ss_n == 1'b1 && busy == 1'b0, "R11 no second frame", int'(busy), 0);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(ss_n && !sck && !mosi && !busy && !done, "R1 reset outputs", int'(ss_n), 1);
        check(slot == '0, "R1 reset slot", int'(slot), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ss_n && !sck && !busy, "R1 idle after reset", int'(busy), 0);
        // directed corners: slot0 en=0 field 7, slot1 en=1 field 0, slot2 en=1 field 7
        xfer(8'hA5, 8'h3C, 3'b110, 3'b110, 3'd7, 3'd7, 1'b0);
        xfer(8'h81, 8'hFF, 3'b110, 3'b110, 3'd0, 3'd0, 1'b0);
        xfer(8'h00, 8'h01, 3'b110, 3'b110, 3'd7, 3'd7, 1'b0);
        // wrapped back to slot 0, mixed enables
        xfer(8'h5A, 8'h80, 3'b011, 3'b010, 3'd3, 3'd5, 1'b0);
        // settings changed and start re-strobed mid-transfer
        xfer(8'hC3, 8'h69, 3'b101, 3'b000, 3'd2, 3'd6, 1'b1);
        for (int i = 0; i < 30; i++) begin
            xfer(W'($urandom), W'($urandom), NSLOT'($urandom), NSLOT'($urandom),
                 3'($urandom), 3'($urandom), ($urandom % 4) == 0);
        end
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule